// File: doc/BRIEF.md
# Clock Loss Detector with Automatic Failover

This block keeps a clock output alive when its main source dies. A free-running backup clock serves as the time base for watching the primary clock. If the primary clock shows no activity for a chosen number of backup-clock cycles, the block raises a loss flag. It then hands the output over to the backup clock through a glitch-free selector. A single input picks the length of the quiet window: a short one of 3 backup cycles, or a long one of 48.

The block returns to the primary source as soon as primary activity is seen again. It applies no recovery delay on the way back. Primary activity is sensed by a divide-by-two flop in the primary domain, synchronized into the backup domain. Each change of the synchronized value clears the quiet-window counter. The selector has one enable per source, and each enable is updated on the falling edge of its own clock. An enable may rise only after the other source's enable has been seen low, so the two sources are never gated onto the output together.

Top module: `clk_failover`

## Requirements
- R1: During reset and directly after it, the loss flag is low and the primary is the selected source. While reset is held, clk_out stays low. Once out of reset with the primary running, clk_out follows clk_pri.
- R2: With tmo_long = 0, after clk_pri stops, the loss flag rises no earlier than the 3rd and no later than the 8th rising edge of clk_bak. This count includes the synchronizer latency.
- R3: With tmo_long = 1, after clk_pri stops, the loss flag rises no earlier than the 48th and no later than the 53rd rising edge of clk_bak.
- R4: While the loss flag is high, clk_out follows clk_bak, starting a few backup cycles after the flag rises.
- R5: When clk_pri restarts, the loss flag falls within 7 rising edges of clk_bak, with no extra recovery timeout. clk_out then follows clk_pri again.
- R6: The two sources are never enabled onto clk_out at the same time. Across every switch, no high or low phase of clk_out is shorter than the shorter half-period of the two input clocks.
- R7: While clk_pri keeps toggling, the loss flag never rises in short-timeout mode. This holds for primary clocks both faster and slower than clk_bak, down to a period of about twice the backup period.
- R8: A primary clock that stops in the high state still triggers failover. The output does not stay stuck high; it moves over to clk_bak.
- R9: The quiet-window counter saturates at the limit currently selected. If tmo_long drops to 0 after more than 3 quiet backup cycles, the flag rises within 2 backup edges. Once raised, the flag is cleared only by primary activity: changing tmo_long does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary clock being watched |
| clk_bak | input | 1 | Free-running backup clock; time base of the detector |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| tmo_long | input | 1 | Timeout select: 0 gives 3 backup cycles, 1 gives 48 |
| lost | output | 1 | High while the primary is judged stopped (backup-clock domain) |
| clk_out | output | 1 | Glitch-free selected clock |

## Verification
The bench times the loss flag in both timeout modes against lower and upper edge counts. A counter with an off-by-one error, or one that ignores the mode input, lands outside the window.

It keeps the primary running at speeds both above and below the backup rate, and watches for a false flag. An activity sensor that samples the primary level instead of a toggle would raise the flag here.

It stops the primary in the high state, which would leave a selector without a forced release stuck high. It also flips the mode input in the middle of a count, to catch a counter that fails to saturate or a flag that drops on its own.

A monitor measures every clk_out phase across all switches. Any enable sequencing that overlaps the two sources, or that changes an enable while its clock is high, shows up as a runt phase.

// File: rtl/clk_failover_pkg.sv
package clk_failover_pkg;

  typedef enum logic {
    SRC_PRI = 1'b0,
    SRC_BAK = 1'b1
  } src_e;

  function automatic int cnt_bits(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/cfo_rst_sync.sv
module cfo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/cfo_activity.sv
module cfo_activity #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_pri,
  input  logic rst_pri_n,
  input  logic clk_bak,
  input  logic rst_bak_n,
  output logic seen
);
  logic                 tog_q;
  logic                 tog_d;
  logic [SYNC_STAGES:0] sh_q;
  logic [SYNC_STAGES:0] sh_d;

  // primary domain: divide-by-two, one change per rising primary edge
  always_comb tog_d = ~tog_q;

  always_ff @(posedge clk_pri or negedge rst_pri_n) begin
    if (!rst_pri_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end

  // backup domain: synchronizer stages plus one history stage
  always_comb sh_d = {sh_q[SYNC_STAGES-1:0], tog_q};

  always_ff @(posedge clk_bak or negedge rst_bak_n) begin
    if (!rst_bak_n) sh_q <= '0;
    else            sh_q <= sh_d;
  end

  assign seen = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/cfo_loss_timer.sv
module cfo_loss_timer
  import clk_failover_pkg::*;
#(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_long,
  input  logic seen,
  output logic lost
);
  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW      = cnt_bits(MAX_CYC);
  localparam logic [CW-1:0] LIM_S = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LIM_L = CW'(LONG_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] lim;
  logic          cnt_en;
  logic          lost_q;
  logic          lost_d;

  always_comb begin
    lim    = sel_long ? LIM_L : LIM_S;
    cnt_en = seen || (cnt_q != lim);
    if (seen) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else begin
      cnt_d  = (cnt_q >= lim) ? lim : cnt_q + 1'b1;
      lost_d = lost_q | (cnt_d == lim);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign lost = lost_q;

  // R2 / R3: flag only rises after a cycle with no primary activity
  p_quiet_before_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> !$past(seen));

  // R5: primary activity clears flag and counter on the next edge
  p_activity_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> (!lost_q && cnt_q == '0));

  // R9: without activity the flag holds, whatever the timeout select does
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !seen) |=> lost_q);
endmodule

// File: rtl/cfo_gate_leg.sv
module cfo_gate_leg (
  input  logic clk,
  input  logic arst_n,
  input  logic want,
  input  logic peer_en,
  output logic en
);
  logic req_q;
  logic req_d;

  always_comb req_d = want & ~peer_en;

  // first stage on the rising edge of its own clock
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  // enable only changes while its own clock is low
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) en <= 1'b0;
    else         en <= req_q;
  end
endmodule

// File: rtl/clk_failover.sv
module clk_failover
  import clk_failover_pkg::*;
#(
  parameter int SHORT_CYC   = 3,
  parameter int LONG_CYC    = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_pri,
  input  logic clk_bak,
  input  logic rst_n,
  input  logic tmo_long,
  output logic lost,
  output logic clk_out
);
  localparam int NSRC = 2;

  logic            rst_pri_n;
  logic            rst_bak_n;
  logic            seen;
  src_e            src;
  logic [NSRC-1:0] leg_clk;
  logic [NSRC-1:0] leg_arst_n;
  logic [NSRC-1:0] leg_want;
  logic [NSRC-1:0] leg_en;

  cfo_rst_sync #(.STAGES(2)) u_rst_pri (
    .clk(clk_pri), .arst_n(rst_n), .rst_n(rst_pri_n)
  );
  cfo_rst_sync #(.STAGES(2)) u_rst_bak (
    .clk(clk_bak), .arst_n(rst_n), .rst_n(rst_bak_n)
  );

  cfo_activity #(.SYNC_STAGES(SYNC_STAGES)) u_activity (
    .clk_pri(clk_pri), .rst_pri_n(rst_pri_n),
    .clk_bak(clk_bak), .rst_bak_n(rst_bak_n),
    .seen(seen)
  );

  cfo_loss_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk(clk_bak), .rst_n(rst_bak_n), .sel_long(tmo_long),
    .seen(seen), .lost(lost)
  );

  assign src = lost ? SRC_BAK : SRC_PRI;

  // index 0 = primary, index 1 = backup
  assign leg_clk    = {clk_bak, clk_pri};
  // a flagged primary leg is released at once, even if its clock is stuck
  assign leg_arst_n = {rst_bak_n, rst_pri_n & ~lost};
  assign leg_want   = {src == SRC_BAK, src == SRC_PRI};

  for (genvar g = 0; g < NSRC; g++) begin : g_leg
    cfo_gate_leg u_leg (
      .clk(leg_clk[g]), .arst_n(leg_arst_n[g]), .want(leg_want[g]),
      .peer_en(leg_en[NSRC-1-g]), .en(leg_en[g])
    );
  end

  assign clk_out = |(leg_clk & leg_en);

  // R6: the two sources are never gated through together
  p_one_source_r6: assert property (@(posedge clk_bak) disable iff (!rst_bak_n)
    !(leg_en[0] && leg_en[1]));

  // R4: a flag held for three samples has the backup leg enabled
  p_backup_enabled_r4: assert property (@(posedge clk_bak) disable iff (!rst_bak_n)
    (lost && $past(lost) && $past(lost, 2)) |-> leg_en[1]);
endmodule

// File: tb/test_clk_failover.sv
`timescale 1ns/100ps
module test_clk_failover;
  logic clk_pri  = 1'b0;
  logic clk_bak  = 1'b0;
  logic rst_n    = 1'b0;
  logic tmo_long = 1'b0;
  logic lost;
  logic clk_out;

  real     pri_half = 4.5;
  logic    pri_run  = 1'b1;
  logic    pri_park = 1'b0;
  int      total = 0;
  int      bad   = 0;
  real     thresh = 3.9;
  realtime last_t = 0;
  int      runts  = 0;
  int      pulses = 0;
  logic    mon_on = 1'b0;

  clk_failover i_clk_failover (
    .clk_pri(clk_pri), .clk_bak(clk_bak), .rst_n(rst_n),
    .tmo_long(tmo_long), .lost(lost), .clk_out(clk_out)
  );

  // 125 MHz backup clock
  always #4 clk_bak = ~clk_bak;

  initial begin
    forever begin
      #(pri_half);
      if (pri_run) clk_pri = ~clk_pri;
      else if (clk_pri != pri_park) clk_pri = pri_park;
    end
  end

  // phase-width monitor on the output (R6)
  always @(clk_out) begin
    if (mon_on) begin
      if ($realtime - last_t < thresh) runts++;
      pulses++;
    end
    last_t = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bak_cycles(input int n);
    repeat (n) @(posedge clk_bak);
    #1;
  endtask

  task automatic check_follow(input bit use_pri, input string req);
    int miss = 0;
    for (int i = 0; i < 6; i++) begin
      if (use_pri) begin
        @(posedge clk_pri); #1; if (clk_out !== 1'b1) miss++;
        @(negedge clk_pri); #1; if (clk_out !== 1'b0) miss++;
      end else begin
        @(posedge clk_bak); #1; if (clk_out !== 1'b1) miss++;
        @(negedge clk_bak); #1; if (clk_out !== 1'b0) miss++;
      end
    end
    chk(miss == 0, req, "clk_out mismatches vs selected source", miss, 0);
  endtask

  task automatic measure_loss(input int lim, input bit park, input string req);
    int n = 0;
    bit hit = 0;
    @(posedge clk_bak); #1;
    pri_park = park;
    pri_run  = 1'b0;
    for (int i = 0; i < lim + 12 && !hit; i++) begin
      @(posedge clk_bak); #1;
      n++;
      if (lost === 1'b1) hit = 1;
    end
    chk(hit && n >= lim && n <= lim + 5, req, "backup edges until loss flag", n, lim);
  endtask

  task automatic resume(input string req);
    int n = 0;
    pri_run = 1'b1;
    for (int i = 0; i < 12 && lost !== 1'b0; i++) begin
      @(posedge clk_bak); #1;
      n++;
    end
    chk(lost === 1'b0 && n <= 7, req, "backup edges until flag clears", n, 7);
    bak_cycles(12);
    check_follow(1'b1, req);
  endtask

  task automatic t_reset();
    #50;
    chk(lost === 1'b0, "R1", "loss flag during reset", int'(lost), 0);
    chk(clk_out === 1'b0, "R1", "clk_out during reset", int'(clk_out), 0);
    @(posedge clk_bak); #1;
    rst_n = 1'b1;
    bak_cycles(10);
    chk(lost === 1'b0, "R1", "loss flag after reset", int'(lost), 0);
    check_follow(1'b1, "R1");
    mon_on = 1'b1;
  endtask

  task automatic t_short();
    tmo_long = 1'b0;
    bak_cycles(2);
    measure_loss(3, 1'b0, "R2");
    bak_cycles(6);
    check_follow(1'b0, "R4");
    resume("R5");
  endtask

  task automatic t_long();
    tmo_long = 1'b1;
    bak_cycles(2);
    measure_loss(48, 1'b0, "R3");
    bak_cycles(20);
    chk(lost === 1'b1, "R4", "flag held while primary stopped", int'(lost), 1);
    check_follow(1'b0, "R4");
    resume("R5");
  endtask

  task automatic t_running(input real half, input string req);
    int hits = 0;
    tmo_long = 1'b0;
    if (half - 0.1 < thresh) thresh = half - 0.1;
    pri_half = half;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk_bak); #1;
      if (lost !== 1'b0) hits++;
    end
    chk(hits == 0, req, "cycles with false loss flag", hits, 0);
    check_follow(1'b1, req);
    pri_half = 4.5;
    bak_cycles(10);
    thresh = 3.9;
  endtask

  task automatic t_stuck_high();
    tmo_long = 1'b0;
    bak_cycles(2);
    measure_loss(3, 1'b1, "R8");
    bak_cycles(6);
    check_follow(1'b0, "R8");
    resume("R8");
  endtask

  task automatic t_retarget();
    tmo_long = 1'b1;
    bak_cycles(2);
    pri_park = 1'b0;
    pri_run  = 1'b0;
    bak_cycles(20);
    chk(lost === 1'b0, "R9", "flag before mode change", int'(lost), 0);
    tmo_long = 1'b0;
    bak_cycles(2);
    chk(lost === 1'b1, "R9", "flag after switch to short limit", int'(lost), 1);
    tmo_long = 1'b1;
    bak_cycles(5);
    chk(lost === 1'b1, "R9", "flag kept after switch back to long", int'(lost), 1);
    resume("R9");
  endtask

  initial begin
    t_reset();
    t_short();
    t_long();
    t_running(7.0, "R7");
    t_running(3.0, "R7");
    t_stuck_high();
    t_retarget();
    chk(runts == 0 && pulses > 100, "R6", "runt phases on clk_out", runts, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    chk(1'b0, "WATCHDOG", "run did not complete", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule